// File: doc/BRIEF.md
# Parallel Printer Port Host Register Interface

This block is the host-facing register file of a PC-style parallel printer port. A host issues single-cycle read and write strobes with a 2-bit offset and an 8-bit data bus. The block decodes three registers at offsets 0, 1 and 2:

- **Offset 0** holds the output byte for the eight data pins.
- **Offset 1** reflects the printer status inputs.
- **Offset 2** holds six control bits. These drive the four printer control lines with per-line polarity. They also set the data bus direction and gate the acknowledge interrupt.

A 3-bit mode input changes two behaviours. In two of the modes the direction bit is overridden, so the data pins are always driven. In the forward extended-capabilities mode (mode 011), data writes are not latched into the output register. Each one is instead pushed, tagged as an address/run-length entry, into a small FIFO that a downstream transmitter drains through a valid/ready interface. The acknowledge input is synchronised and edge-detected to raise a sticky interrupt, which is cleared by reading the status register.

Top module: `pport_regs`

## Requirements
- R1: After reset:
  - the data register and control bits 0..5 are 0
  - `pd_oe_o`=1
  - `nstrobe_o`=1, `nautofd_o`=1, `ninit_o`=0, `nslctin_o`=1
  - `irq_o`=0
  - the FIFO is empty (`fifo_valid_o`=0)
  - `rdata_o`=0
- R2: In every mode except 011, a write to offset 0 stores `wdata_i`. From the next cycle `pd_o` shows that byte without inversion.
- R3: A read of offset 0 returns the current level of `pd_i[7:0]`, not the stored register.
- R4: A read of offset 1 returns the following. Bits 2..0 are 0. Bit 3 is `fault_n_i`, bit 4 is `select_i`, bit 5 is `perror_i` and bit 6 is `ack_n_i`. Bit 7 is the inverse of `busy_i`.
- R5: A write to offset 2 stores `wdata_i[5:0]`. A read of offset 2 returns those bits with bits 7..6 equal to 0. A read of offset 3 returns 0x00.
- R6: Each control line takes its level from one control bit:
  - `nstrobe_o` = inverse of control bit 0
  - `nautofd_o` = inverse of control bit 1
  - `ninit_o` = control bit 2, not inverted
  - `nslctin_o` = inverse of control bit 3
- R7: In modes 000 and 010, `pd_oe_o` is 1 whatever control bit 5 holds. In every other mode, `pd_oe_o` is the inverse of control bit 5.
- R8: A low-to-high transition on `ack_n_i` while control bit 4 is 1 sets a pending flag. `irq_o` equals the pending flag ANDed with control bit 4. A read of offset 1 clears the flag.
- R9: A rising `ack_n_i` edge while control bit 4 is 0 leaves nothing pending. Setting bit 4 afterwards does not raise `irq_o`.
- R10: In mode 011 with control bit 5 = 0, a write to offset 0 leaves `pd_o` unchanged. It pushes `{1'b1, wdata_i}` into the FIFO. Entries appear on `fifo_data_o` in write order, with bit 8 as the tag.
- R11: The FIFO holds 16 entries, and `fifo_full_o` is 1 when all 16 are occupied. A write while the FIFO is full is discarded.
- R12: In mode 011 with control bit 5 = 1, a write to offset 0 changes neither `pd_o` nor the FIFO contents.
- R13: `rdata_o` updates on the clock edge that samples `rd_i`=1. It holds its value while `rd_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| rdata_o | output | 8 | Registered read data |
| mode_i | input | 3 | Port mode |
| pd_o | output | 8 | Data pin output value |
| pd_oe_o | output | 1 | Data pin output enable |
| pd_i | input | 8 | Data pin levels |
| nstrobe_o | output | 1 | Strobe line, active low |
| nautofd_o | output | 1 | Auto-feed line, active low |
| ninit_o | output | 1 | Initialise line |
| nslctin_o | output | 1 | Select-in line, active low |
| fault_n_i | input | 1 | Fault status, active low |
| select_i | input | 1 | Select status |
| perror_i | input | 1 | Paper error status |
| ack_n_i | input | 1 | Acknowledge, active low |
| busy_i | input | 1 | Busy status |
| irq_o | output | 1 | Acknowledge interrupt request |
| fifo_valid_o | output | 1 | FIFO head valid |
| fifo_data_o | output | 9 | FIFO head: tag in bit 8, byte in bits 7..0 |
| fifo_ready_i | input | 1 | Pop FIFO head when valid |
| fifo_full_o | output | 1 | FIFO full |

## Verification
The bench builds the block with its defaults: a 16-entry FIFO and a two-stage acknowledge synchroniser. At depth 16 the full boundary and a discarded over-full write are reached in a short directed burst. With two synchroniser stages the interrupt appears a fixed few cycles after an acknowledge edge, so a short wait observes it. Random mixes of modes, offsets and control values exercise the direction override and the redirection of data writes into the FIFO against a bench model. The queued entries are drained and compared in order at the end.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PD_W   = 8;
  localparam int CTRL_W = 6;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  localparam logic [2:0] PM_COMPAT = 3'b000;
  localparam logic [2:0] PM_BIDIR  = 3'b001;
  localparam logic [2:0] PM_FIFO   = 3'b010;
  localparam logic [2:0] PM_ECP    = 3'b011;

  localparam int CB_STB  = 0;
  localparam int CB_AFD  = 1;
  localparam int CB_INIT = 2;
  localparam int CB_SLIN = 3;
  localparam int CB_IEN  = 4;
  localparam int CB_DIR  = 5;

  function automatic logic [7:0] status_byte(input logic busy, input logic ack_n,
                                             input logic perr, input logic sel,
                                             input logic fault_n);
    return {~busy, ack_n, perr, sel, fault_n, 3'b000};
  endfunction
endpackage

// File: rtl/pport_sync_edge.sv
module pport_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= RST_VAL;
    else         chain_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[i] <= RST_VAL;
      else         chain_q[i] <= chain_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pport_tag_fifo.sv
module pport_tag_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign data_o  = mem_q[rp_q];
  assign do_push = push_i & ~full_o;  // full-time writes are dropped
  assign do_pop  = pop_i & valid_o;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= inc(wp_q);
      if (do_pop)  rp_q <= inc(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic [7:0]  rdata_o,
  input  logic [2:0]  mode_i,
  output logic [7:0]  pd_o,
  output logic        pd_oe_o,
  input  logic [7:0]  pd_i,
  output logic        nstrobe_o,
  output logic        nautofd_o,
  output logic        ninit_o,
  output logic        nslctin_o,
  input  logic        fault_n_i,
  input  logic        select_i,
  input  logic        perror_i,
  input  logic        ack_n_i,
  input  logic        busy_i,
  output logic        irq_o,
  output logic        fifo_valid_o,
  output logic [8:0]  fifo_data_o,
  input  logic        fifo_ready_i,
  output logic        fifo_full_o
);
  localparam int TW = PD_W + 1;

  logic [PD_W-1:0]   data_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [7:0]        rdata_q, rd_mux;
  logic              pend_q;
  logic              ecp_mode, force_out, wr_data, wr_ctrl, rd_stat;
  logic              data_load, fifo_push, ack_rise;

  always_comb begin
    ecp_mode  = (mode_i == PM_ECP);
    force_out = (mode_i == PM_COMPAT) || (mode_i == PM_FIFO);
    wr_data   = wr_i && (addr_i == A_DATA);
    wr_ctrl   = wr_i && (addr_i == A_CTRL);
    rd_stat   = rd_i && (addr_i == A_STAT);
    data_load = wr_data && !ecp_mode;
    // reverse-direction ECP writes are dropped
    fifo_push = wr_data && ecp_mode && !ctrl_q[CB_DIR];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (data_load) data_q <= wdata_i;
      if (wr_ctrl)   ctrl_q <= wdata_i[CTRL_W-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      A_DATA:  rd_mux = pd_i;
      A_STAT:  rd_mux = status_byte(busy_i, ack_n_i, perror_i, select_i, fault_n_i);
      A_CTRL:  rd_mux = {{(8-CTRL_W){1'b0}}, ctrl_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  pport_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ack_n_i),
    .rise_o (ack_rise)
  );

  // new edge wins over a same-cycle status read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pend_q <= 1'b0;
    else if (ack_rise && ctrl_q[CB_IEN]) pend_q <= 1'b1;
    else if (rd_stat)                 pend_q <= 1'b0;
  end
  assign irq_o = pend_q & ctrl_q[CB_IEN];

  pport_tag_fifo #(.W(TW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .data_i  ({1'b1, wdata_i}),
    .pop_i   (fifo_ready_i),
    .valid_o (fifo_valid_o),
    .data_o  (fifo_data_o),
    .full_o  (fifo_full_o)
  );

  assign pd_o      = data_q;
  assign pd_oe_o   = force_out | ~ctrl_q[CB_DIR];
  assign nstrobe_o = ~ctrl_q[CB_STB];
  assign nautofd_o = ~ctrl_q[CB_AFD];
  assign ninit_o   =  ctrl_q[CB_INIT];
  assign nslctin_o = ~ctrl_q[CB_SLIN];
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk
  import pport_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] rdata_o,
  input logic [2:0] mode_i,
  input logic [7:0] pd_o,
  input logic       pd_oe_o,
  input logic       nstrobe_o,
  input logic       ninit_o,
  input logic       irq_o,
  input logic       fifo_valid_o,
  input logic [8:0] fifo_data_o,
  input logic       fifo_full_o
);
  logic unused_bits;
  assign unused_bits = ^{wdata_i[7:5], wdata_i[3], wdata_i[1], fifo_data_o[7:0]};

  p_oe_forced_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PM_COMPAT || mode_i == PM_FIFO) |-> pd_oe_o);

  p_ctrl_pins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_CTRL) |=> (ninit_o == $past(wdata_i[2])) && (nstrobe_o == !$past(wdata_i[0])));

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_CTRL && !wdata_i[4]) |=> !irq_o);

  p_rdata_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  p_stat_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_STAT) |=> (rdata_o[2:0] == 3'b000));

  p_pd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PM_ECP && wr_i && addr_i == A_DATA) |=> $stable(pd_o));

  p_tag_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_valid_o |-> fifo_data_o[8]);

  p_full_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_o |-> fifo_valid_o);
endmodule

bind pport_regs pport_regs_chk u_chk (.*);

// File: tb/sim_pport_regs.sv
module sim_pport_regs;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, pd_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [2:0] mode_i = 3'b000;
  logic       fault_n_i = 1'b1, select_i = 1'b0, perror_i = 1'b0, ack_n_i = 1'b1, busy_i = 1'b0;
  logic       fifo_ready_i = 1'b0;
  logic [7:0] rdata_o, pd_o;
  logic       pd_oe_o, nstrobe_o, nautofd_o, ninit_o, nslctin_o, irq_o;
  logic       fifo_valid_o, fifo_full_o;
  logic [8:0] fifo_data_o;

  int total = 0, fails = 0;
  logic [7:0] data_m = '0;
  logic [5:0] ctrl_m = '0;
  logic [8:0] q_m [16];
  int qn = 0;

  always #2 clk_i = ~clk_i;

  pport_regs u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_oe(input logic [2:0] m, input logic [5:0] c);
    return (m == 3'b000 || m == 3'b010) ? 1'b1 : ~c[5];
  endfunction

  function automatic logic [7:0] exp_stat();
    return {~busy_i, ack_n_i, perror_i, select_i, fault_n_i, 3'b000};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    if (a == 2'd2) ctrl_m = d[5:0];
    if (a == 2'd0) begin
      if (mode_i != 3'b011) data_m = d;
      else if (!ctrl_m[5] && qn < 16) begin q_m[qn] = {1'b1, d}; qn++; end
    end
    @(posedge clk_i); @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    rd_i = 1'b0; d = rdata_o;
  endtask

  task automatic pop_check(input string req);
    check(req, fifo_valid_o, 1'b1);
    check(req, fifo_data_o, q_m[0]);
    for (int i = 0; i < 15; i++) q_m[i] = q_m[i+1];
    qn--;
    fifo_ready_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    fifo_ready_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) @(posedge clk_i);
    fails++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    void'($urandom(32'd1234));
    wait_cyc(3);
    check("R1 pd_o", pd_o, 8'h00);
    check("R1 pd_oe", pd_oe_o, 1'b1);
    check("R1 ctrl pins", {nstrobe_o, nautofd_o, ninit_o, nslctin_o}, 4'b1101);
    check("R1 irq", irq_o, 1'b0);
    check("R1 fifo empty", fifo_valid_o, 1'b0);
    check("R1 rdata", rdata_o, 8'h00);
    rst_ni = 1'b1;
    wait_cyc(1);
    rd(2'd2, r); check("R1 ctrl reg", r, 8'h00);

    // R2/R3
    wr(2'd0, 8'hA5); check("R2 pd_o", pd_o, 8'hA5);
    pd_i = 8'h3C; rd(2'd0, r); check("R3 pin read", r, 8'h3C);
    // R13: rdata holds after pins change with no strobe
    pd_i = 8'hC3; wait_cyc(3); check("R13 rdata hold", rdata_o, 8'h3C);

    // R5/R6/R7
    wr(2'd2, 8'hFF); rd(2'd2, r); check("R5 ctrl read", r, 8'h3F);
    rd(2'd3, r); check("R5 offset3", r, 8'h00);
    check("R6 pins set", {nstrobe_o, nautofd_o, ninit_o, nslctin_o}, 4'b0010);
    wr(2'd2, 8'h04); check("R6 pins 04", {nstrobe_o, nautofd_o, ninit_o, nslctin_o}, 4'b1111);
    wr(2'd2, 8'h20);
    mode_i = 3'b000; wait_cyc(1); check("R7 mode000 forced", pd_oe_o, 1'b1);
    mode_i = 3'b010; wait_cyc(1); check("R7 mode010 forced", pd_oe_o, 1'b1);
    mode_i = 3'b001; wait_cyc(1); check("R7 mode001 input", pd_oe_o, 1'b0);
    mode_i = 3'b111; wait_cyc(1); check("R7 mode111 input", pd_oe_o, 1'b0);
    wr(2'd2, 8'h00); check("R7 mode111 output", pd_oe_o, 1'b1);
    mode_i = 3'b000;

    // R4
    for (int i = 0; i < 20; i++) begin
      {busy_i, perror_i, select_i, fault_n_i} = 4'($urandom);
      rd(2'd1, r); check("R4 status", r, exp_stat());
    end

    // R8
    wr(2'd2, 8'h10);
    ack_n_i = 1'b0; wait_cyc(4); check("R8 no irq on fall", irq_o, 1'b0);
    ack_n_i = 1'b1; wait_cyc(4); check("R8 irq raised", irq_o, 1'b1);
    rd(2'd1, r); wait_cyc(1); check("R8 irq cleared", irq_o, 1'b0);
    // R9
    wr(2'd2, 8'h00);
    ack_n_i = 1'b0; wait_cyc(4); ack_n_i = 1'b1; wait_cyc(4);
    check("R9 disabled", irq_o, 1'b0);
    wr(2'd2, 8'h10); wait_cyc(2); check("R9 no late irq", irq_o, 1'b0);
    wr(2'd2, 8'h00);

    // R10
    mode_i = 3'b011;
    wr(2'd0, 8'h11); wr(2'd0, 8'h22); wr(2'd0, 8'h33);
    check("R10 pd unchanged", pd_o, 8'hA5);
    pop_check("R10 order"); pop_check("R10 order"); pop_check("R10 order");
    check("R10 drained", fifo_valid_o, 1'b0);
    // R11
    for (int i = 0; i < 18; i++) wr(2'd0, 8'(8'h40 + i));
    check("R11 full", fifo_full_o, 1'b1);
    check("R11 count", qn, 16);
    for (int i = 0; i < 16; i++) pop_check("R11 drop extra");
    check("R11 empty", fifo_valid_o, 1'b0);
    // R12
    wr(2'd2, 8'h20);
    wr(2'd0, 8'h99);
    check("R12 fifo untouched", fifo_valid_o, 1'b0);
    check("R12 pd untouched", pd_o, 8'hA5);
    check("R7 ecp input", pd_oe_o, 1'b0);
    wr(2'd2, 8'h00);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 3));
      mode_i = 3'($urandom);
      pd_i = 8'($urandom);
      {busy_i, perror_i, select_i, fault_n_i} = 4'($urandom);
      case (op)
        0: wr(2'd2, 8'($urandom) & 8'hEF);
        1: wr(2'd0, 8'($urandom));
        default: begin
          logic [1:0] a;
          logic [7:0] e;
          a = 2'($urandom);
          case (a)
            2'd0: e = pd_i;
            2'd1: e = exp_stat();
            2'd2: e = {2'b00, ctrl_m};
            default: e = 8'h00;
          endcase
          rd(a, r); check("R3 R4 R5 random read", r, e);
        end
      endcase
      check("R2 R10 R12 random pd", pd_o, data_m);
      check("R7 random oe", pd_oe_o, exp_oe(mode_i, ctrl_m));
      check("R11 random full", fifo_full_o, qn == 16);
    end
    while (qn > 0) pop_check("R10 random drain");
    check("R10 random empty", fifo_valid_o, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule